// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, frame by frame, whether a received Ethernet frame should be kept. The destination address bytes arrive one per strobe right after a start-of-frame pulse. An end-of-frame pulse then delivers the final frame length, an error indication and a reset-frame indication. One cycle after the end-of-frame pulse, the block presents an accept or reject decision. It also reports whether the frame was a runt and whether it was a reset frame. Downstream status logic uses these flags.

A small byte-wide register port holds the configuration. It contains a filter-mode register and a six-byte station address. The mode register sets one of four acceptance levels: nothing, own address plus broadcast, the previous plus multicast, or every frame. It also holds four single-bit options: a five-byte partial address compare, runt acceptance, reset-frame acceptance, and a stored test bit.

Top module: `rx_addr_filter`

## Requirements
- R1: The mode register sits at offset 0x05. It resets to 0x00. Writes keep bits 7, 4, 3, 2, 1 and 0, and a read returns bits 6 and 5 as zero. For example, writing 0xFF reads back 0x9F.
- R2: The station address sits at offsets 0x08 to 0x0D and resets to zero. The register at 0x08+k is compared with the k-th destination byte to arrive, counting from 0. Each register reads back what was written. Any other offset reads 0x00.
- R3: With mode bits [1:0] = 00, every frame is rejected.
- R4: With mode bits [1:0] = 01, a frame is accepted when its destination equals the station address or is all 0xFF. Other destinations are rejected. An address-based accept requires all six destination bytes to have arrived.
- R5: With mode bits [1:0] = 10, a frame is also accepted when bit 0 of its first destination byte is 1 (multicast).
- R6: With mode bits [1:0] = 11, every frame passes the address stage, even one with fewer than six destination bytes.
- R7: When mode bit 4 is set, the last destination byte (byte 5) is left out of the station address compare.
- R8: A frame whose length is below 64 raises runt_flag. It is rejected unless mode bit 3 is set.
- R9: A frame that ends with rst_frame high raises rst_pkt_flag. It is rejected unless mode bit 2 is set.
- R10: A frame that ends with frame_err high is always rejected.
- R11: decision_valid, accept and both flags update in the cycle after frame_end. They hold until a frame_start, which clears all four in the cycle after it.
- R12: Mode bit 7 is stored and read back but has no effect on the decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| frame_start | input | 1 | Start-of-frame pulse, precedes the destination bytes |
| da_valid | input | 1 | Destination byte strobe |
| da_byte | input | 8 | Destination address byte |
| frame_end | input | 1 | End-of-frame pulse, after the last destination byte |
| frame_len | input | 11 | Final frame length in bytes, valid with frame_end |
| frame_err | input | 1 | Frame error, valid with frame_end |
| rst_frame | input | 1 | Frame is a reset frame, valid with frame_end |
| decision_valid | output | 1 | A decision is being presented |
| accept | output | 1 | Frame accepted |
| runt_flag | output | 1 | Decided frame was a runt |
| rst_pkt_flag | output | 1 | Decided frame was a reset frame |

## Verification
Some properties are checked on every cycle. The decision and flags stay stable between pulses, and frame_start clears the outputs. Mode 00 always rejects and mode 11 always accepts a clean frame. A runt, reset or error frame is dropped whenever its enable bit is clear. The byte counter stays within the address length, and the unused mode bits read as zero. Other behaviour needs the bench's frame scenarios. These cover matches against particular station addresses, broadcast and multicast classification, the five-byte compare ignoring only the last byte, the length 63/64 runt boundary, short destinations under the address-based modes, and the test bit having no effect.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int OFS_MODE = 5;
  localparam int OFS_STA  = 8;

  typedef enum logic [1:0] {
    ACC_NONE   = 2'b00,
    ACC_UNI_BC = 2'b01,
    ACC_MCAST  = 2'b10,
    ACC_ALL    = 2'b11
  } acc_e;

  typedef struct packed {
    logic test;
    logic five_byte;
    logic en_runt;
    logic en_rst;
    acc_e acc;
  } mode_t;

  function automatic mode_t unpack_mode(input logic [7:0] b);
    mode_t m;
    m.test      = b[7];
    m.five_byte = b[4];
    m.en_runt   = b[3];
    m.en_rst    = b[2];
    m.acc       = acc_e'(b[1:0]);
    return m;
  endfunction

  function automatic logic [7:0] pack_mode(input mode_t m);
    return {m.test, 2'b00, m.five_byte, m.en_runt, m.en_rst, m.acc};
  endfunction

endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int REG_AW     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [REG_AW-1:0]       reg_addr,
  input  logic [7:0]              reg_wdata,
  output logic [7:0]              reg_rdata,
  output acc_e                    acc_mode,
  output logic                    five_byte,
  output logic                    en_runt,
  output logic                    en_rst,
  output logic [8*ADDR_BYTES-1:0] sta_addr
);

  localparam logic [REG_AW-1:0] MODE_OFS = REG_AW'(OFS_MODE);

  mode_t                   mode_q, mode_d;
  logic [8*ADDR_BYTES-1:0] sta_q, sta_d;

  always_comb begin
    mode_d = mode_q;
    sta_d  = sta_q;
    if (reg_wr) begin
      if (reg_addr == MODE_OFS) mode_d = unpack_mode(reg_wdata);
      for (int i = 0; i < ADDR_BYTES; i++) begin
        if (reg_addr == REG_AW'(OFS_STA + i)) sta_d[i*8 +: 8] = reg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      sta_q  <= '0;
    end else if (reg_wr) begin
      mode_q <= mode_d;
      sta_q  <= sta_d;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == MODE_OFS) reg_rdata = pack_mode(mode_q);
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (reg_addr == REG_AW'(OFS_STA + i)) reg_rdata = sta_q[i*8 +: 8];
    end
  end

  assign acc_mode  = mode_q.acc;
  assign five_byte = mode_q.five_byte;
  assign en_runt   = mode_q.en_runt;
  assign en_rst    = mode_q.en_rst;
  assign sta_addr  = sta_q;

  // R1: the two unimplemented mode bits never read as one
  p_mode_unused_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == MODE_OFS) |-> (reg_rdata[6:5] == 2'b00));

  // R1: a mode write is visible on the read port in the next cycle
  p_mode_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == MODE_OFS) |=>
      (pack_mode(mode_q) == ($past(reg_wdata) & 8'h9F)));

endmodule

// File: rtl/rxf_da_match.sv
module rxf_da_match #(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_start,
  input  logic                    da_valid,
  input  logic [7:0]              da_byte,
  input  logic [8*ADDR_BYTES-1:0] sta_addr,
  output logic [ADDR_BYTES-1:0]   hit_vec,
  output logic                    all_seen,
  output logic                    bcast,
  output logic                    mcast
);

  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  logic [ADDR_BYTES-1:0] eq;
  logic                  is_ff;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [ADDR_BYTES-1:0] hit_q, hit_d;
  logic                  bc_q, bc_d, mc_q, mc_d;
  logic                  take;

  genvar g;
  generate
    for (g = 0; g < ADDR_BYTES; g++) begin : g_cmp
      assign eq[g] = (da_byte == sta_addr[g*8 +: 8]);
    end
  endgenerate

  assign is_ff = &da_byte;
  assign take  = da_valid && (cnt_q < CNT_W'(ADDR_BYTES));

  always_comb begin
    cnt_d = cnt_q;
    hit_d = hit_q;
    bc_d  = bc_q;
    mc_d  = mc_q;
    if (frame_start) begin
      cnt_d = '0;
      hit_d = '0;
      bc_d  = 1'b1;
      mc_d  = 1'b0;
    end else if (take) begin
      hit_d[cnt_q[IDX_W-1:0]] = eq[cnt_q[IDX_W-1:0]];
      bc_d  = bc_q & is_ff;
      if (cnt_q == '0) mc_d = da_byte[0];
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hit_q <= '0;
      bc_q  <= 1'b0;
      mc_q  <= 1'b0;
    end else if (frame_start || take) begin
      cnt_q <= cnt_d;
      hit_q <= hit_d;
      bc_q  <= bc_d;
      mc_q  <= mc_d;
    end
  end

  assign hit_vec  = hit_q;
  assign all_seen = (cnt_q == CNT_W'(ADDR_BYTES));
  assign bcast    = bc_q;
  assign mcast    = mc_q;

  // R2: bytes past the address length are never counted
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ADDR_BYTES));

  // R5: the group bit is taken from the first byte of the frame
  p_mcast_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !frame_start && cnt_q == '0) |=> (mcast == $past(da_byte[0])));

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int LEN_W      = 11,
  parameter int MIN_LEN    = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  acc_e                  acc_mode,
  input  logic                  five_byte,
  input  logic                  en_runt,
  input  logic                  en_rst,
  input  logic [ADDR_BYTES-1:0] hit_vec,
  input  logic                  all_seen,
  input  logic                  bcast,
  input  logic                  mcast,
  input  logic                  frame_start,
  input  logic                  frame_end,
  input  logic [LEN_W-1:0]      frame_len,
  input  logic                  frame_err,
  input  logic                  rst_frame,
  output logic                  decision_valid,
  output logic                  accept,
  output logic                  runt_flag,
  output logic                  rst_pkt_flag
);

  logic [ADDR_BYTES-1:0] skip_mask;
  logic own, addr_pass, is_runt, acc_now;
  logic vld_q, vld_d, acc_q, acc_d, runt_q, runt_d, rp_q, rp_d;

  always_comb begin
    skip_mask = '0;
    skip_mask[ADDR_BYTES-1] = five_byte;
  end

  assign own     = all_seen && (&(hit_vec | skip_mask));
  assign is_runt = (frame_len < LEN_W'(MIN_LEN));

  always_comb begin
    case (acc_mode)
      ACC_UNI_BC: addr_pass = own || (all_seen && bcast);
      ACC_MCAST:  addr_pass = own || (all_seen && (bcast || mcast));
      ACC_ALL:    addr_pass = 1'b1;
      default:    addr_pass = 1'b0;
    endcase
  end

  assign acc_now = addr_pass && !frame_err &&
                   (!is_runt || en_runt) && (!rst_frame || en_rst);

  always_comb begin
    vld_d  = vld_q;
    acc_d  = acc_q;
    runt_d = runt_q;
    rp_d   = rp_q;
    if (frame_end) begin
      vld_d  = 1'b1;
      acc_d  = acc_now;
      runt_d = is_runt;
      rp_d   = rst_frame;
    end else if (frame_start) begin
      vld_d  = 1'b0;
      acc_d  = 1'b0;
      runt_d = 1'b0;
      rp_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      acc_q  <= 1'b0;
      runt_q <= 1'b0;
      rp_q   <= 1'b0;
    end else if (frame_end || frame_start) begin
      vld_q  <= vld_d;
      acc_q  <= acc_d;
      runt_q <= runt_d;
      rp_q   <= rp_d;
    end
  end

  assign decision_valid = vld_q;
  assign accept         = acc_q;
  assign runt_flag      = runt_q;
  assign rst_pkt_flag   = rp_q;

  p_off_rejects_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && acc_mode == ACC_NONE) |=> !accept);

  p_all_accepts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && acc_mode == ACC_ALL && !frame_err && !rst_frame &&
     frame_len >= LEN_W'(MIN_LEN)) |=> accept);

  p_runt_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && frame_len < LEN_W'(MIN_LEN) && !en_runt) |=> (!accept && runt_flag));

  p_rst_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && rst_frame && !en_rst) |=> (!accept && rst_pkt_flag));

  p_err_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && frame_err |=> !accept);

  p_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> decision_valid);

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !frame_end) |=> (!decision_valid && !accept && !runt_flag && !rst_pkt_flag));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !frame_end) |=>
      ($stable(decision_valid) && $stable(accept) && $stable(runt_flag) && $stable(rst_pkt_flag)));

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int REG_AW     = 4,
  parameter int LEN_W      = 11,
  parameter int MIN_LEN    = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              frame_start,
  input  logic              da_valid,
  input  logic [7:0]        da_byte,
  input  logic              frame_end,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              frame_err,
  input  logic              rst_frame,
  output logic              decision_valid,
  output logic              accept,
  output logic              runt_flag,
  output logic              rst_pkt_flag
);

  acc_e                    acc_mode;
  logic                    five_byte, en_runt, en_rst;
  logic [8*ADDR_BYTES-1:0] sta_addr;
  logic [ADDR_BYTES-1:0]   hit_vec;
  logic                    all_seen, bcast, mcast;

  rxf_regs #(.ADDR_BYTES(ADDR_BYTES), .REG_AW(REG_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .acc_mode  (acc_mode),
    .five_byte (five_byte),
    .en_runt   (en_runt),
    .en_rst    (en_rst),
    .sta_addr  (sta_addr)
  );

  rxf_da_match #(.ADDR_BYTES(ADDR_BYTES)) u_match (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .da_valid    (da_valid),
    .da_byte     (da_byte),
    .sta_addr    (sta_addr),
    .hit_vec     (hit_vec),
    .all_seen    (all_seen),
    .bcast       (bcast),
    .mcast       (mcast)
  );

  rxf_decide #(.ADDR_BYTES(ADDR_BYTES), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_decide (
    .clk            (clk),
    .rst_n          (rst_n),
    .acc_mode       (acc_mode),
    .five_byte      (five_byte),
    .en_runt        (en_runt),
    .en_rst         (en_rst),
    .hit_vec        (hit_vec),
    .all_seen       (all_seen),
    .bcast          (bcast),
    .mcast          (mcast),
    .frame_start    (frame_start),
    .frame_end      (frame_end),
    .frame_len      (frame_len),
    .frame_err      (frame_err),
    .rst_frame      (rst_frame),
    .decision_valid (decision_valid),
    .accept         (accept),
    .runt_flag      (runt_flag),
    .rst_pkt_flag   (rst_pkt_flag)
  );

endmodule

// File: tb/rx_addr_filter_tb.sv
`timescale 1ns/1ps
module rx_addr_filter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        frame_start = 1'b0;
  logic        da_valid = 1'b0;
  logic [7:0]  da_byte = '0;
  logic        frame_end = 1'b0;
  logic [10:0] frame_len = '0;
  logic        frame_err = 1'b0;
  logic        rst_frame = 1'b0;
  logic        decision_valid, accept, runt_flag, rst_pkt_flag;

  always #2 clk = ~clk;

  rx_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
    .da_valid(da_valid), .da_byte(da_byte), .frame_end(frame_end),
    .frame_len(frame_len), .frame_err(frame_err), .rst_frame(rst_frame),
    .decision_valid(decision_valid), .accept(accept), .runt_flag(runt_flag),
    .rst_pkt_flag(rst_pkt_flag)
  );

  int total = 0;
  int fails = 0;
  string cur_req = "R11";

  // behavioural reference state
  logic [7:0] m_mode = 8'h00;
  logic [7:0] m_sta [6] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
  logic [7:0] m_q [$];
  bit m_vld = 0, m_acc = 0, m_runt = 0, m_rp = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit ref_accept(input int len, input bit err, input bit rf);
    bit full, own, bc, mc, pass;
    full = (m_q.size() >= 6);
    own = full; bc = full; mc = full && m_q[0][0];
    if (full) begin
      for (int i = 0; i < 6; i++) begin
        if (!(i == 5 && m_mode[4]) && m_q[i] != m_sta[i]) own = 0;
        if (m_q[i] != 8'hFF) bc = 0;
      end
    end
    case (m_mode[1:0])
      2'b00: pass = 0;
      2'b01: pass = own || bc;
      2'b10: pass = own || bc || mc;
      default: pass = 1;
    endcase
    if (err) pass = 0;
    if (len < 64 && !m_mode[3]) pass = 0;
    if (rf && !m_mode[2]) pass = 0;
    return pass;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld = 0; m_acc = 0; m_runt = 0; m_rp = 0;
      m_q.delete();
    end else begin
      if (frame_end) begin
        m_vld = 1;
        m_acc = ref_accept(int'(frame_len), frame_err, rst_frame);
        m_runt = (frame_len < 64);
        m_rp = rst_frame;
      end else if (frame_start) begin
        m_vld = 0; m_acc = 0; m_runt = 0; m_rp = 0;
      end
      if (frame_start) m_q.delete();
      else if (da_valid && m_q.size() < 6) m_q.push_back(da_byte);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check({cur_req, " cycle"}, {28'd0, decision_valid, accept, runt_flag, rst_pkt_flag},
            {28'd0, m_vld, m_acc, m_runt, m_rp});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (a == 4'h5) m_mode = d & 8'h9F;
    else if (a >= 4'h8 && a <= 4'hD) m_sta[a - 4'h8] = d;
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, {24'd0, reg_rdata}, {24'd0, exp});
  endtask

  task automatic send(input string req, input logic [7:0] b [$], input int len,
                      input bit err, input bit rf);
    cur_req = req;
    @(negedge clk);
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    foreach (b[i]) begin
      da_valid = 1; da_byte = b[i];
      @(negedge clk);
    end
    da_valid = 0;
    frame_end = 1; frame_len = 11'(len); frame_err = err; rst_frame = rf;
    @(negedge clk);
    frame_end = 0; frame_err = 0; rst_frame = 0;
    #1;
    check({req, " accept"}, {31'd0, accept}, {31'd0, m_acc});
    check({req, " valid"}, {31'd0, decision_valid}, 32'd1);
  endtask

  task automatic expect_acc(input string req, input bit exp);
    check({req, " expected decision"}, {31'd0, accept}, {31'd0, exp});
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [7:0] own6 [$] = '{8'h02, 8'h07, 8'h01, 8'hAA, 8'hBB, 8'hCC};
    logic [7:0] bc6 [$]  = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    logic [7:0] uni6 [$] = '{8'h02, 8'h07, 8'h01, 8'hAA, 8'hBB, 8'hCD};
    logic [7:0] mc6 [$]  = '{8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01};
    logic [7:0] b4x [$]  = '{8'h02, 8'h07, 8'h01, 8'hAA, 8'hB0, 8'hCC};
    logic [7:0] own5 [$] = '{8'h02, 8'h07, 8'h01, 8'hAA, 8'hBB};
    logic [7:0] two [$]  = '{8'h44, 8'h55};
    #5;
    // reset state
    check("R11 reset valid", {31'd0, decision_valid}, 32'd0);
    check("R11 reset accept", {31'd0, accept}, 32'd0);
    @(negedge clk);
    rst_n = 1;
    rd_check("R1 reset mode", 4'h5, 8'h00);
    rd_check("R2 reset station", 4'h8, 8'h00);

    // register port
    wr(4'h5, 8'hFF);
    rd_check("R1 mode mask", 4'h5, 8'h9F);
    foreach (own6[i]) wr(4'(8 + i), own6[i]);
    rd_check("R2 station byte0", 4'h8, 8'h02);
    rd_check("R2 station byte5", 4'hD, 8'hCC);
    rd_check("R2 unused offset", 4'hE, 8'h00);

    // R3
    wr(4'h5, 8'h00);
    send("R3", own6, 100, 0, 0); expect_acc("R3", 0);
    send("R3", bc6, 100, 0, 0);  expect_acc("R3", 0);

    // R4
    wr(4'h5, 8'h01);
    send("R4", own6, 100, 0, 0); expect_acc("R4", 1);
    send("R4", bc6, 100, 0, 0);  expect_acc("R4", 1);
    send("R4", uni6, 100, 0, 0); expect_acc("R4", 0);
    send("R4", mc6, 100, 0, 0);  expect_acc("R4", 0);
    send("R4", own5, 100, 0, 0); expect_acc("R4", 0);

    // R5
    wr(4'h5, 8'h02);
    send("R5", mc6, 100, 0, 0);  expect_acc("R5", 1);
    send("R5", uni6, 100, 0, 0); expect_acc("R5", 0);
    send("R5", own6, 100, 0, 0); expect_acc("R5", 1);

    // R6
    wr(4'h5, 8'h03);
    send("R6", uni6, 100, 0, 0); expect_acc("R6", 1);
    send("R6", two, 100, 0, 0);  expect_acc("R6", 1);

    // R7
    wr(4'h5, 8'h11);
    send("R7", uni6, 100, 0, 0); expect_acc("R7", 1);
    send("R7", b4x, 100, 0, 0);  expect_acc("R7", 0);

    // R8
    wr(4'h5, 8'h01);
    send("R8", own6, 40, 0, 0); expect_acc("R8", 0);
    check("R8 runt flag", {31'd0, runt_flag}, 32'd1);
    send("R8", own6, 63, 0, 0); expect_acc("R8", 0);
    send("R8", own6, 64, 0, 0); expect_acc("R8", 1);
    check("R8 no runt at 64", {31'd0, runt_flag}, 32'd0);
    wr(4'h5, 8'h09);
    send("R8", own6, 40, 0, 0); expect_acc("R8", 1);

    // R9
    wr(4'h5, 8'h01);
    send("R9", own6, 100, 0, 1); expect_acc("R9", 0);
    check("R9 reset flag", {31'd0, rst_pkt_flag}, 32'd1);
    wr(4'h5, 8'h05);
    send("R9", own6, 100, 0, 1); expect_acc("R9", 1);

    // R10
    wr(4'h5, 8'h0F);
    send("R10", own6, 100, 1, 0); expect_acc("R10", 0);

    // R12
    wr(4'h5, 8'h81);
    send("R12", own6, 100, 0, 0); expect_acc("R12", 1);
    send("R12", uni6, 100, 0, 0); expect_acc("R12", 0);

    // R11: hold, then clear by frame_start
    send("R11", own6, 100, 0, 0);
    cur_req = "R11";
    repeat (5) @(negedge clk);
    check("R11 held accept", {31'd0, accept}, 32'd1);
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    #1;
    check("R11 cleared valid", {31'd0, decision_valid}, 32'd0);
    check("R11 cleared accept", {31'd0, accept}, 32'd0);
    repeat (3) @(negedge clk);
    report();
  end

endmodule